// File: doc/BRIEF.md
# Clock Pulse Skipper Throttle

This block thins out a stream of clock-enable pulses so that a downstream clock domain runs at a lower effective rate. A throttle depth says what share of the incoming pulses, in percent, is to be removed; the surviving pulses are spread evenly over time rather than bunched into bursts. The result is a pulse-enable signal that a clock gate elsewhere on the chip can use.

The depth comes from one of two sources, chosen by a mode input. In percentage mode it is a 7-bit value from 0 to 100. In level mode it is a 2-bit code that maps onto fixed depths. Either source may change at run time. A change takes effect on the next enabled pulse and does not clear the fractional state built up so far, so a change of depth never produces a burst of extra pulses.

Internally a modulo-100 accumulator adds the pass share (100 minus the depth) for every incoming pulse. A pulse is let through whenever the sum reaches or passes 100, and 100 is then taken off the sum.

Top module: `pulse_skip_throttle`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `pulse_en` is 0, and the accumulator restarts from 0.
- R2: With an effective depth of 0, every cycle with `clk_en_in` high is followed one cycle later by `pulse_en` high.
- R3: With an effective depth of 100, `pulse_en` stays 0. A percentage input above 100 is treated as 100.
- R4: A cycle with `clk_en_in` low gives `pulse_en` low one cycle later and leaves the accumulator unchanged, so the pattern resumes where it stopped.
- R5: With constant depth D from reset, the n-th enabled pulse (counting from 1) passes exactly when floor(n*(100-D)/100) exceeds floor((n-1)*(100-D)/100); over 100 enabled pulses exactly 100-D pass.
- R6: `mode_sel` = 0 takes the depth from `depth_pct`; `mode_sel` = 1 takes it from `level_code`, with code 0 meaning 0 %, code 1 meaning 50 %, code 2 meaning 75 % and code 3 meaning 85 %.
- R7: A change of depth or mode keeps the accumulator value. The next enabled pulse adds the new pass share to the old remainder.
- R8: `pulse_en` is registered. It reflects the `clk_en_in` and depth of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en_in | input | 1 | Incoming clock-enable pulse stream |
| mode_sel | input | 1 | 0: percentage depth, 1: level code |
| depth_pct | input | 7 | Skip depth in percent (values above 100 clamp to 100) |
| level_code | input | 2 | Skip level code (0/1/2/3 → 0/50/75/85 %) |
| pulse_en | output | 1 | Thinned pulse-enable output |

## Verification
The bench builds the block with its default parameters: a modulus of 100, a 7-bit percentage input and level depths of 50, 75 and 85. These values put both ends of the depth range within a few cycles: depth 0 passes everything, and depth 100 or the clamped value 127 passes nothing. The 85 % level shows the even spread within 20 pulses. Enable gaps and depth changes in the middle of a stream check that the remainder is carried across them, against a credit model kept in the bench.

// File: rtl/pst_pkg.sv
package pst_pkg;

  localparam int unsigned FULL_SCALE = 100;

  // Clamp a raw percentage to the legal range.
  function automatic int unsigned clamp_depth(input int unsigned raw, input int unsigned full);
    return (raw > full) ? full : raw;
  endfunction

  // Share of pulses that survive for a given depth.
  function automatic int unsigned pass_share(input int unsigned depth, input int unsigned full);
    return full - clamp_depth(depth, full);
  endfunction

  // Level code to depth lookup.
  function automatic int unsigned level_depth(input logic [1:0] code,
                                              input int unsigned d1,
                                              input int unsigned d2,
                                              input int unsigned d3);
    case (code)
      2'd0:    return 0;
      2'd1:    return d1;
      2'd2:    return d2;
      default: return d3;
    endcase
  endfunction

endpackage

// File: rtl/pst_depth_select.sv
module pst_depth_select
  import pst_pkg::*;
#(
  parameter int unsigned FULL   = FULL_SCALE,
  parameter int unsigned PCT_W  = 7,
  parameter int unsigned LVL1   = 50,
  parameter int unsigned LVL2   = 75,
  parameter int unsigned LVL3   = 85,
  localparam int unsigned SHR_W = $clog2(FULL + 1)
) (
  input  logic             mode_sel,
  input  logic [PCT_W-1:0] depth_pct,
  input  logic [1:0]       level_code,
  output logic [SHR_W-1:0] pass_amt
);

  int unsigned pct_depth;
  int unsigned lvl_depth;
  int unsigned eff_depth;

  always_comb begin
    pct_depth = clamp_depth(32'(depth_pct), FULL);
    lvl_depth = clamp_depth(level_depth(level_code, LVL1, LVL2, LVL3), FULL);
    eff_depth = mode_sel ? lvl_depth : pct_depth;
    pass_amt  = SHR_W'(pass_share(eff_depth, FULL));
  end

  // R3: the pass share never exceeds the full scale
  always_comb begin
    a_r3_share_in_range: assert (32'(pass_amt) <= FULL);
  end

endmodule

// File: rtl/pst_accum.sv
module pst_accum #(
  parameter int unsigned FULL   = 100,
  localparam int unsigned SHR_W = $clog2(FULL + 1),
  localparam int unsigned ACC_W = $clog2(2 * FULL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [SHR_W-1:0] pass_amt,
  output logic             wrap,
  output logic [ACC_W-1:0] acc_q
);

  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    sum   = acc_q + ACC_W'(pass_amt);
    wrap  = (sum >= ACC_W'(FULL));
    acc_d = acc_q;
    if (step) acc_d = wrap ? (sum - ACC_W'(FULL)) : sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R5: the remainder stays below the full scale
  a_r5_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < ACC_W'(FULL));

  // R4: without a step the remainder is held
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(acc_q));

endmodule

// File: rtl/pulse_skip_throttle.sv
module pulse_skip_throttle
  import pst_pkg::*;
#(
  parameter int unsigned FULL  = FULL_SCALE,
  parameter int unsigned PCT_W = 7,
  parameter int unsigned LVL1  = 50,
  parameter int unsigned LVL2  = 75,
  parameter int unsigned LVL3  = 85
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_in,
  input  logic             mode_sel,
  input  logic [PCT_W-1:0] depth_pct,
  input  logic [1:0]       level_code,
  output logic             pulse_en
);

  localparam int unsigned SHR_W = $clog2(FULL + 1);
  localparam int unsigned ACC_W = $clog2(2 * FULL);

  logic [SHR_W-1:0] pass_amt;
  logic             wrap;
  logic [ACC_W-1:0] acc_q;
  logic             pass_now;

  pst_depth_select #(
    .FULL(FULL), .PCT_W(PCT_W), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_sel (
    .mode_sel  (mode_sel),
    .depth_pct (depth_pct),
    .level_code(level_code),
    .pass_amt  (pass_amt)
  );

  pst_accum #(.FULL(FULL)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (clk_en_in),
    .pass_amt(pass_amt),
    .wrap    (wrap),
    .acc_q   (acc_q)
  );

  assign pass_now = clk_en_in & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_en <= 1'b0;
    else        pulse_en <= pass_now;
  end

  // R4: an output pulse needs an input pulse one cycle earlier
  a_r4_no_pulse_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_en |-> $past(clk_en_in));

  // R2: a full pass share lets every input pulse through
  a_r2_zero_depth_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_in && (32'(pass_amt) == FULL)) |=> pulse_en);

  // R3: a zero pass share blocks every pulse
  a_r3_full_depth_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_amt == '0) |=> !pulse_en);

endmodule

// File: tb/pulse_skip_throttle_tb_top.sv
module pulse_skip_throttle_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en_in = 1'b0;
  logic       mode_sel = 1'b0;
  logic [6:0] depth_pct = '0;
  logic [1:0] level_code = '0;
  logic       pulse_en;

  always #5 clk = ~clk;

  pulse_skip_throttle dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_in(clk_en_in), .mode_sel(mode_sel),
    .depth_pct(depth_pct), .level_code(level_code), .pulse_en(pulse_en)
  );

  typedef struct { bit val; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  int credit = 0;
  bit done = 0;

  function automatic int model_depth(bit m, int pct, int lvl);
    int d;
    if (m) d = (lvl == 3) ? 85 : (lvl == 2) ? 75 : (lvl == 1) ? 50 : 0;
    else   d = (pct >= 100) ? 100 : pct;
    return d;
  endfunction

  // Driver: apply one cycle of stimulus at the falling edge and predict.
  task automatic drive(bit en, bit m, int pct, int lvl, string req);
    exp_t e;
    @(negedge clk);
    clk_en_in  = en;
    mode_sel   = m;
    depth_pct  = 7'(pct);
    level_code = 2'(lvl);
    e.req = req;
    e.val = 1'b0;
    if (en) begin
      credit += 100 - model_depth(m, pct, lvl);
      if (credit >= 100) begin
        e.val = 1'b1;
        credit -= 100;
      end
    end
    exp_q.push_back(e);
  endtask

  // Monitor: compare after the edge that registers each prediction.
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (pulse_en !== e.val) begin
        failures++;
        $display("FAIL %s pulse_en=%0b expected=%0b", e.req, pulse_en, e.val);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog pulse_en=%0b expected=finish", pulse_en);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int passed;
    int prev, cur;
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (pulse_en !== 1'b0) begin
      failures++;
      $display("FAIL R1 pulse_en=%0b expected=0", pulse_en);
    end
    @(negedge clk);
    rst_n = 1'b1;
    credit = 0;
    checks++;
    if (pulse_en !== 1'b0) begin
      failures++;
      $display("FAIL R1 pulse_en=%0b expected=0 after release", pulse_en);
    end

    // R2: depth 0 passes all, R8 one-cycle latency
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 0, 0, "R2");
    drive(1'b0, 1'b0, 0, 0, "R8");
    // R3: depth 100 and clamped 127
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 100, 0, "R3");
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 127, 0, "R3");
    // R4: gaps hold the remainder
    for (int i = 0; i < 12; i++) drive(i % 3 != 0, 1'b0, 50, 0, "R4");
    // R6: each level code, and mode 0 ignoring level
    for (int l = 0; l < 4; l++)
      for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 0, l, "R6");
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 100, 0, "R6");
    // R7: change of depth mid-stream
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 30, 0, "R7");
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 60, 0, "R7");
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, 0, 2, "R7");

    // R5: spread check from a fresh reset with depth 85 and 37
    @(negedge clk);
    rst_n = 1'b0;
    clk_en_in = 1'b0;
    repeat (2) @(negedge clk);
    wait (exp_q.size() == 0);
    rst_n = 1'b1;
    credit = 0;
    for (int d = 37; d <= 85; d += 48) begin
      passed = 0;
      for (int n = 1; n <= 100; n++) begin
        @(negedge clk);
        clk_en_in = 1'b1;
        mode_sel = 1'b0;
        depth_pct = 7'(d);
        @(posedge clk);
        #2;
        prev = ((n - 1) * (100 - d)) / 100;
        cur  = (n * (100 - d)) / 100;
        checks++;
        if (pulse_en !== (cur > prev)) begin
          failures++;
          $display("FAIL R5 depth=%0d n=%0d pulse_en=%0b expected=%0b", d, n, pulse_en, cur > prev);
        end
        if (pulse_en) passed++;
      end
      checks++;
      if (passed != 100 - d) begin
        failures++;
        $display("FAIL R5 depth=%0d passed=%0d expected=%0d", d, passed, 100 - d);
      end
    end
    @(negedge clk);
    clk_en_in = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule